// File: doc/BRIEF.md
# Time-Sliced Optical Switch Ring Sequencer

This block steers one five-port optical switch (north, south, east, west and a local port) through a fixed, repeating sequence of time slots. A table holds one 12-bit ring pattern for each slot. A set bit turns the matching ring resonator on for the whole slot. A slot counter moves forward on a chip-wide slot tick and starts again at zero after the last programmed slot. At each step the counter loads the next table pattern into the registered ring outputs. The current slot number is driven out as well, so that the local gateways know which source and destination pair owns the optical path.

Software fills the table while the block is disabled, then enables it. A global frame-sync pulse sends the counter back to slot 0, which keeps every switch on the chip aligned. The network routes X first and then Y, so no packet arriving from the north or the south ever turns east or west. The table will not accept any pattern that would light a ring for one of those turns. Such a write is dropped, and a sticky error flag is raised.

Top module: `tdm_ring_ctrl`

## Requirements
- R1: After reset, slot_idx is 0, ring_on is all zeros, cfg_err is 0 and every table entry holds zero.
- R2: While en is low at a clock edge, the outputs after that edge are ring_on = 0 and slot_idx = 0.
- R3: While en is high, a tick without fsync moves slot_idx from k to k+1. From slot frame_last it moves to 0. Without tick or fsync, slot_idx and ring_on hold their values.
- R4: While en is high, fsync sets slot_idx to 0 at the next edge, whether or not tick is high in that cycle.
- R5: ring_on is registered. It takes the table entry of the new slot on the same edge at which slot_idx changes. At the first edge with en high, the block shows slot 0 and entry 0.
- R6: A write (wr_en high, address wr_addr, data wr_data) is stored only when en is low. A write made while en is high leaves the table unchanged.
- R7: Ring bit encoding: bit 0 is north-to-east, bit 1 is north-to-west, bit 2 is south-to-east and bit 3 is south-to-west. Bits 4 to 11 are the legal paths. A write with any of bits 0 to 3 set is dropped, and it sets cfg_err, which stays high until reset.
- R8: If frame_last is lowered below the current slot, the next tick sends slot_idx to 0. Slots above frame_last are never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| en | input | 1 | run enable; low allows table writes and turns all rings off |
| tick | input | 1 | one-cycle slot advance strobe |
| fsync | input | 1 | frame sync, returns the counter to slot 0 |
| frame_last | input | 6 | index of the last slot in the frame |
| wr_en | input | 1 | table write strobe |
| wr_addr | input | 6 | table entry to write |
| wr_data | input | 12 | ring pattern to write |
| ring_on | output | 12 | per-ring on/off for the current slot |
| slot_idx | output | 6 | current slot number |
| cfg_err | output | 1 | sticky flag: a forbidden-turn pattern was rejected |

## Verification
A corrupted slot counter appears at slot_idx, and ring_on shows the wrong pattern on the very next edge, because both are loaded together. A table entry that was stored wrongly, or lost, stays hidden until its slot comes around. The bench therefore gives every programmed entry a distinct pattern and walks through each slot. A forbidden pattern that got into the table would light one of the low four ring bits within one frame, and a missed rejection shows at once as cfg_err staying low.

// File: rtl/tdm_ring_pkg.sv
package tdm_ring_pkg;
    localparam int RING_N = 12;
    localparam int TURN_N = 4;

    typedef logic [RING_N-1:0] ring_vec_t;

    // bit 0: N->E, bit 1: N->W, bit 2: S->E, bit 3: S->W (never routed under X-then-Y)
    localparam ring_vec_t XY_FORBID = ring_vec_t'((1 << TURN_N) - 1);

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_STEP  = 2'd1,
        SEQ_ZERO  = 2'd2
    } seq_op_e;

    function automatic logic turn_ok(input ring_vec_t pat);
        return (pat & XY_FORBID) == '0;
    endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
    import tdm_ring_pkg::*;
#(
    parameter int N_SLOTS = 64,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] frame_last,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic [SLOT_W-1:0] slot_q
);
    seq_op_e op;

    always_comb begin
        if (!en || fsync)                 op = SEQ_ZERO;
        else if (tick && slot_q >= frame_last) op = SEQ_ZERO;
        else if (tick)                    op = SEQ_STEP;
        else                              op = SEQ_HOLD;
    end

    always_comb begin
        unique case (op)
            SEQ_ZERO: slot_nxt = '0;
            SEQ_STEP: slot_nxt = slot_q + 1'b1;
            default:  slot_nxt = slot_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_nxt;
    end
endmodule

// File: rtl/tdm_sched_table.sv
module tdm_sched_table
    import tdm_ring_pkg::*;
#(
    parameter int N_SLOTS = 64,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_open,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  ring_vec_t         wr_data,
    input  logic [SLOT_W-1:0] rd_addr,
    output ring_vec_t         rd_data,
    output logic              err_q
);
    ring_vec_t mem [N_SLOTS];
    logic      take, bad;

    assign bad  = wr_en && wr_open && !turn_ok(wr_data);
    assign take = wr_en && wr_open && turn_ok(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOTS; i++) mem[i] <= '0;
        end else if (take) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tdm_ring_ctrl.sv
module tdm_ring_ctrl
    import tdm_ring_pkg::*;
#(
    parameter int N_SLOTS = 64,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] frame_last,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_addr,
    input  logic [11:0]       wr_data,
    output logic [11:0]       ring_on,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              cfg_err
);
    logic [SLOT_W-1:0] slot_nxt;
    ring_vec_t         entry;

    tdm_slot_counter #(.N_SLOTS(N_SLOTS)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .fsync(fsync),
        .frame_last(frame_last), .slot_nxt(slot_nxt), .slot_q(slot_idx)
    );

    tdm_sched_table #(.N_SLOTS(N_SLOTS)) u_tab (
        .clk(clk), .rst(rst), .wr_open(!en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(slot_nxt),
        .rd_data(entry), .err_q(cfg_err)
    );

    always_ff @(posedge clk) begin
        if (rst)     ring_on <= '0;
        else if (en) ring_on <= entry;
        else         ring_on <= '0;
    end
endmodule

// File: rtl/tdm_ring_ctrl_chk.sv
module tdm_ring_ctrl_chk
    import tdm_ring_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              tick,
    input logic              fsync,
    input logic [SLOT_W-1:0] frame_last,
    input logic              wr_en,
    input logic [11:0]       wr_data,
    input logic [11:0]       ring_on,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              cfg_err
);
    a_r2_dark_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ring_on == '0 && slot_idx == '0));

    a_r3_wrap_at_last: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !fsync && slot_idx == frame_last) |=> slot_idx == '0);

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !fsync && $past(en)) |=> ($stable(slot_idx) && $stable(ring_on)));

    a_r4_sync_zero: assert property (@(posedge clk) disable iff (rst)
        (en && fsync) |=> slot_idx == '0);

    a_r7_no_xy_turn: assert property (@(posedge clk) disable iff (rst)
        (ring_on & XY_FORBID) == '0);

    a_r7_err_raised: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en && !turn_ok(wr_data)) |=> cfg_err);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);
endmodule

bind tdm_ring_ctrl tdm_ring_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .fsync(fsync),
    .frame_last(frame_last), .wr_en(wr_en), .wr_data(wr_data),
    .ring_on(ring_on), .slot_idx(slot_idx), .cfg_err(cfg_err)
);

// File: tb/tdm_ring_ctrl_tb.sv
module tdm_ring_ctrl_tb;
    logic       clk = 0;
    logic       rst = 1;
    logic       en = 0, tick = 0, fsync = 0, wr_en = 0;
    logic [5:0] frame_last = 0, wr_addr = 0;
    logic [11:0] wr_data = 0;
    logic [11:0] ring_on;
    logic [5:0]  slot_idx;
    logic        cfg_err;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [11:0] exp_tab [64];

    always #4 clk = ~clk;

    tdm_ring_ctrl u_dut (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .fsync(fsync),
        .frame_last(frame_last), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ring_on(ring_on), .slot_idx(slot_idx),
        .cfg_err(cfg_err)
    );

    function automatic logic [11:0] pat(input int i);
        return 12'((i * 37 + 5) << 4) & 12'hFF0;
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_entry(input int a, input logic [11:0] d);
        wr_en = 1; wr_addr = 6'(a); wr_data = d;
        step();
        wr_en = 0;
        if (!en && (d & 12'h00F) == 0) exp_tab[a] = d;
    endtask

    task automatic pulse_tick();
        tick = 1; step(); tick = 0;
    endtask

    task automatic t_reset();
        chk("R1 slot", 12'(slot_idx), 0);
        chk("R1 ring", ring_on, 0);
        chk("R1 err", 12'(cfg_err), 0);
    endtask

    task automatic t_run_frame();
        for (int i = 0; i < 4; i++) write_entry(i, pat(i));
        frame_last = 3;
        en = 1; step();
        chk("R5 first slot", 12'(slot_idx), 0);
        chk("R5 first entry", ring_on, pat(0));
        for (int k = 1; k <= 4; k++) begin
            pulse_tick();
            chk("R3 slot advance", 12'(slot_idx), 12'(k % 4));
            chk("R5 ring follows slot", ring_on, exp_tab[k % 4]);
        end
        pulse_tick();
        step(); step();
        chk("R3 hold slot", 12'(slot_idx), 1);
        chk("R3 hold ring", ring_on, pat(1));
    endtask

    task automatic t_fsync();
        pulse_tick();
        chk("R3 pre-sync", 12'(slot_idx), 2);
        fsync = 1; step(); fsync = 0;
        chk("R4 sync zero", 12'(slot_idx), 0);
        chk("R4 sync ring", ring_on, pat(0));
        pulse_tick();
        fsync = 1; tick = 1; step(); fsync = 0; tick = 0;
        chk("R4 sync beats tick", 12'(slot_idx), 0);
    endtask

    task automatic t_write_enabled();
        write_entry(1, 12'hAB0);
        pulse_tick();
        chk("R6 enabled write ignored", ring_on, pat(1));
        chk("R6 table ref", exp_tab[1], pat(1));
    endtask

    task automatic t_forbidden();
        en = 0; step();
        chk("R2 ring off", ring_on, 0);
        chk("R2 slot zero", 12'(slot_idx), 0);
        write_entry(2, 12'h011);
        chk("R7 err raised", 12'(cfg_err), 1);
        write_entry(3, 12'h108);
        en = 1; step();
        pulse_tick(); pulse_tick();
        chk("R7 dropped entry 2", ring_on, pat(2));
        pulse_tick();
        chk("R7 dropped entry 3", ring_on, pat(3));
        chk("R7 err sticky", 12'(cfg_err), 1);
    endtask

    task automatic t_shrink();
        frame_last = 1;
        pulse_tick();
        chk("R8 wrap beyond last", 12'(slot_idx), 0);
        pulse_tick(); pulse_tick();
        chk("R8 short frame", 12'(slot_idx), 0);
        en = 0; step();
        chk("R2 disabled ring", ring_on, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) exp_tab[i] = 0;
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_run_frame();
        t_fsync();
        t_write_enabled();
        t_forbidden();
        t_shrink();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule